// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block negates a binary word that arrives one bit per clock, least significant bit first, and sends the negated word out as a bit stream in the same order. It does not use an adder. While the low-order bits are zero, and for the lowest 1 bit, it passes the input bit straight through. After that lowest 1, it inverts every later bit of the word. A single flag holds the only state: whether a 1 has already been seen in the current word.

A word can have any length. A start-of-word pulse, given together with the word's first valid bit, marks where each word begins. Words can follow one another with no gap. The source can also stall at any point by dropping the input valid. Each output bit appears one clock after its input bit, and a matching output valid goes with it, so a consumer downstream can take the result at the same rate as the input.

Top module: `serial_negator`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and on the first clock after it is released, `neg_bit` and `neg_vld` are both 0.
- R2: `neg_vld` equals the value `bit_vld` had one clock earlier.
- R3: Input bits below the lowest 1 of a word are zero, and they come out unchanged as 0.
- R4: The lowest 1 bit of a word comes out unchanged as 1, one clock after it is accepted.
- R5: Every valid bit of a word after its lowest 1 comes out inverted, so a word gives its two's complement modulo 2^n. For example, 10010100 gives 01101100 and 11111111 gives 00000001.
- R6: If `word_start` is 1 together with a valid bit, the seen-a-one flag is cleared before that bit is processed, so the bit is copied whatever the previous word held.
- R7: A word that is all zeros comes out as all zeros.
- R8: While `bit_vld` is 0, the flag keeps its value and `neg_vld` is 0 on the next clock. A word with idle cycles inside it comes out the same as one sent without gaps.
- R9: If `word_start` is 1 while `bit_vld` is 0, it has no effect. Bits after it that belong to the same word are still inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial input bit, LSB first |
| bit_vld | input | 1 | `bit_in` holds a valid bit this clock |
| word_start | input | 1 | First bit of a new word; acted on only together with `bit_vld` |
| neg_bit | output | 1 | Serial negated bit, one clock after its input |
| neg_vld | output | 1 | `neg_bit` is valid |

## Verification
The hardest case to reach is a word that stalls after its lowest 1 while a stray start pulse arrives during the stall. To pass, the flag must survive both the idle cycle and the ignored pulse. The bench sends each word a second time with an idle cycle after every bit and holds `word_start` high in each of those idle cycles. It also sends words back to back with no gap, so the flag clear of R6 is tested right after a word whose last bits were being inverted.

// File: rtl/serial_negator.sv
module serial_negator (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic word_start,
  output logic neg_bit,
  output logic neg_vld
);

  logic one_seen;
  logic seen_now;
  logic flip_bit;

  assign seen_now = one_seen & ~word_start;
  assign flip_bit = bit_in ^ seen_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      one_seen <= 1'b0;
      neg_bit  <= 1'b0;
      neg_vld  <= 1'b0;
    end else begin
      neg_vld <= bit_vld;
      if (bit_vld) begin
        neg_bit  <= flip_bit;
        one_seen <= seen_now | bit_in;
      end
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> neg_vld);

  // R8
  idle_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !neg_vld);

  // R8
  idle_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(one_seen));

  // R6
  start_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && word_start) |=> (neg_bit == $past(bit_in)));

  // R4
  first_one_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_in) |=> one_seen);

  // R5
  invert_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !word_start && one_seen) |=> (neg_bit != $past(bit_in)));

endmodule

// File: tb/sim_serial_negator.sv
`timescale 1ns/1ps
module sim_serial_negator;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic word_start = 1'b0;
  logic neg_bit;
  logic neg_vld;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_negator u0 (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .word_start(word_start), .neg_bit(neg_bit), .neg_vld(neg_vld)
  );

  localparam int NVEC = 10;
  localparam logic [15:0] VECS [NVEC] = '{
    {8'h94, 8'h6C}, {8'h01, 8'hFF}, {8'h80, 8'h80}, {8'h00, 8'h00},
    {8'hFF, 8'h01}, {8'h0A, 8'hF6}, {8'h7F, 8'h81}, {8'h55, 8'hAB},
    {8'h3C, 8'hC4}, {8'h02, 8'hFE}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic send_word(input logic [7:0] w, input bit gaps, output logic [7:0] got);
    logic vld_ok;
    vld_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bit_in = w[i];
      word_start = (i == 0);
      bit_vld = 1'b1;
      @(negedge clk);
      got[i] = neg_bit;
      if (neg_vld !== 1'b1) vld_ok = 1'b0;
      if (gaps) begin
        bit_vld = 1'b0;
        word_start = 1'b1;
        bit_in = ~bit_in;
        @(negedge clk);
        check("R8 idle neg_vld", {7'd0, neg_vld}, 8'd0);
        check("R8 idle neg_bit held", {7'd0, neg_bit}, {7'd0, got[i]});
      end
    end
    bit_vld = 1'b0;
    word_start = 1'b0;
    check("R2 neg_vld during word", {7'd0, vld_ok}, 8'd1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    check("R1 reset neg_bit", {7'd0, neg_bit}, 8'd0);
    check("R1 reset neg_vld", {7'd0, neg_vld}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {6'd0, neg_bit, neg_vld}, 8'd0);

    // R3 R4 R5 R6 R7: back-to-back words, no gaps
    for (int k = 0; k < NVEC; k++) begin
      send_word(VECS[k][15:8], 1'b0, got);
      check("R5 table word", got, VECS[k][7:0]);
    end
    @(negedge clk);
    check("R2 neg_vld drops", {7'd0, neg_vld}, 8'd0);

    // R8 R9: stalls with stray start pulses
    for (int k = 0; k < NVEC; k++) begin
      send_word(VECS[k][15:8], 1'b1, got);
      check("R9 gapped word", got, VECS[k][7:0]);
    end

    // R6: word full of inversion followed by copy on start
    send_word(8'h01, 1'b0, got);
    send_word(8'h00, 1'b0, got);
    check("R7 zero after one", got, 8'h00);
    send_word(8'h10, 1'b0, got);
    check("R3 zeros copied below one", got, 8'hF0);

    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule